// File: doc/BRIEF.md
# MQ Probability Stage

This block is the front half of a pipelined binary arithmetic encoder of the MQ kind. Each cycle it can take one pair made of a context index and a decision bit. It looks up the adaptive state of that context, codes the decision against the 16-bit interval length register A, and updates both the context and A. For every pair it emits one compact record for the code register stage further down the pipeline. The record holds a renormalisation shift count, a 16-bit probability value and a flag that says whether that value must be added to the code register. The code register, byte output, bit stuffing and termination are not part of this block.

A context holds a predicted symbol and a row of a 47-entry probability state table. Each row gives the probability estimate, the successor state after a correct prediction, the successor state after a wrong prediction, and a flag that inverts the prediction. The context read takes two pipeline stages. When the same context is used by two pairs in a row, or by two pairs with one other pair between them, the new context state is forwarded around the memory. This keeps the rate at one pair per cycle with no stall. The renormalisation shift is never done one bit at a time. After a subtraction it is one or two bits. When A is loaded from the probability value, the shift is the leading-zero count of that value, which is held in the table row.

Top module: `mq_prob_stage`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. A holds 0x8000. Context k is in the state given by field INIT_IDX[6k+5:6k] with prediction 0, and that field defaults to 0.
- R2: Each accepted pair (in_valid and in_ready high at a rising edge) produces exactly one record, in input order. If out_ready stays high, the record is valid in the cycle after the next rising edge.
- R3: When the decision equals the prediction and A-Qe is at least 0x8000, the record is hit=1, prob=Qe, shift=0. A becomes A-Qe and the context state is unchanged.
- R4: If the decision equals the prediction and A-Qe < 0x8000, then: when A-Qe < Qe, A is loaded from Qe with hit=0; otherwise A becomes A-Qe with hit=1 and prob=Qe. If the decision differs from the prediction, then: when A-Qe < Qe, A becomes A-Qe with hit=1 and prob=Qe; otherwise A is loaded from Qe with hit=0. prob is 0 whenever hit is 0.
- R5: shift equals the number of left shifts that set bit 15 of the new A, which is 1 or 2 after a subtraction or the leading-zero count of Qe after a load. After every record, bit 15 of A is set.
- R6: A wrong prediction moves the context to its wrong-prediction successor. It also inverts the prediction when the switch flag is set, which is true for states 0, 6 and 14. A correct prediction moves to the correct-prediction successor only when shift is nonzero. The table is the standard 47-state MQ table.
- R7: Pairs on the same context in consecutive cycles are coded with no stall, as if each saw the state left by the one before.
- R8: Pairs on the same context with one other pair between them are coded correctly, with no stall.
- R9: While out_valid is high and out_ready is low, the record stays unchanged and in_ready is low. No record is lost or duplicated.
- R10: A non-default INIT_IDX sets the starting state of each context on its own. For example, state 5 gives a first probability of 0x0221 and state 3 gives 0x0AC1.
- R11: Contexts evolve independently, and in_cx must be below NCTX while in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Context/decision pair present |
| in_ready | output | 1 | Pair will be accepted at the next edge |
| in_cx | input | CXW | Context index |
| in_bit | input | 1 | Decision bit |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Downstream takes the record |
| out_shift | output | 4 | Renormalisation shift count |
| out_prob | output | 16 | Value to add to the code register |
| out_hit | output | 1 | Code register must add out_prob |

## Verification
A wrong context state, a missed forward or a corrupted A register changes no port at once. It shows up in the first later record that depends on it. That record carries a wrong probability value, hit flag or shift count, usually within a few pairs on the same context. The bench therefore keeps its own encoder model and compares every record. It drives dense streams of repeats at distance one and two, and runs under random back-pressure. A hazard slip then shows up within a couple of records, not only in a final result.

// File: rtl/mq_prob_pkg.sv
package mq_prob_pkg;
  localparam int IW   = 6;   // state index width
  localparam int PW   = 16;  // probability / interval width
  localparam int SHW  = 4;   // shift count width

  typedef struct packed {
    logic [PW-1:0]  qe;
    logic [SHW-1:0] qsh;   // leading zeros of qe, precomputed
    logic [IW-1:0]  nm;    // successor on correct prediction
    logic [IW-1:0]  nl;    // successor on wrong prediction
    logic           sw;    // invert prediction on wrong guess
  } st_row_t;

  typedef struct packed {
    logic    mps;
    st_row_t row;
  } ctx_word_t;

  function automatic logic [PW-1:0] qe_of(input logic [IW-1:0] i);
    case (i)
      6'd0, 6'd6, 6'd14, 6'd46: qe_of = 16'h5601;
      6'd1, 6'd19:  qe_of = 16'h3401;
      6'd2, 6'd25:  qe_of = 16'h1801;
      6'd3, 6'd30:  qe_of = 16'h0AC1;
      6'd4, 6'd33:  qe_of = 16'h0521;
      6'd5, 6'd36:  qe_of = 16'h0221;
      6'd7, 6'd15:  qe_of = 16'h5401;
      6'd8, 6'd17:  qe_of = 16'h4801;
      6'd9, 6'd18:  qe_of = 16'h3801;
      6'd10, 6'd20: qe_of = 16'h3001;
      6'd11, 6'd22: qe_of = 16'h2401;
      6'd12, 6'd24: qe_of = 16'h1C01;
      6'd13, 6'd26: qe_of = 16'h1601;
      6'd16: qe_of = 16'h5101;
      6'd21: qe_of = 16'h2801;
      6'd23: qe_of = 16'h2201;
      6'd27: qe_of = 16'h1401;
      6'd28: qe_of = 16'h1201;
      6'd29: qe_of = 16'h1101;
      6'd31: qe_of = 16'h09C1;
      6'd32: qe_of = 16'h08A1;
      6'd34: qe_of = 16'h0441;
      6'd35: qe_of = 16'h02A1;
      6'd37: qe_of = 16'h0141;
      6'd38: qe_of = 16'h0111;
      6'd39: qe_of = 16'h0085;
      6'd40: qe_of = 16'h0049;
      6'd41: qe_of = 16'h0025;
      6'd42: qe_of = 16'h0015;
      6'd43: qe_of = 16'h0009;
      6'd44: qe_of = 16'h0005;
      default: qe_of = 16'h0001;
    endcase
  endfunction

  function automatic logic [IW-1:0] nm_of(input logic [IW-1:0] i);
    if (i == 6'd5)       nm_of = 6'd38;
    else if (i == 6'd13) nm_of = 6'd29;
    else if (i >= 6'd45) nm_of = i;
    else                 nm_of = i + 6'd1;
  endfunction

  function automatic logic [IW-1:0] nl_of(input logic [IW-1:0] i);
    case (i)
      6'd0: nl_of = 6'd1;
      6'd1: nl_of = 6'd6;
      6'd2: nl_of = 6'd9;
      6'd3: nl_of = 6'd12;
      6'd4: nl_of = 6'd29;
      6'd5: nl_of = 6'd33;
      6'd6: nl_of = 6'd6;
      6'd7, 6'd8, 6'd9, 6'd14, 6'd15: nl_of = 6'd14;
      6'd10: nl_of = 6'd17;
      6'd11: nl_of = 6'd18;
      6'd12: nl_of = 6'd20;
      6'd13: nl_of = 6'd21;
      6'd46: nl_of = 6'd46;
      default: nl_of = (i <= 6'd20) ? i - 6'd1 : i - 6'd2;
    endcase
  endfunction

  function automatic logic [SHW-1:0] lzc16(input logic [PW-1:0] v);
    lzc16 = '0;
    for (int b = 0; b < PW; b++) begin
      if (v[b]) lzc16 = SHW'(PW - 1 - b);
    end
  endfunction

  function automatic st_row_t row_of(input logic [IW-1:0] i);
    row_of.qe  = qe_of(i);
    row_of.qsh = lzc16(qe_of(i));
    row_of.nm  = nm_of(i);
    row_of.nl  = nl_of(i);
    row_of.sw  = (i == 6'd0) || (i == 6'd6) || (i == 6'd14);
  endfunction
endpackage

// File: rtl/mq_state_rom.sv
module mq_state_rom import mq_prob_pkg::*; (
  input  logic [IW-1:0] idx,
  output st_row_t       row
);
  always_comb row = row_of(idx);
endmodule

// File: rtl/mq_ctx_store.sv
module mq_ctx_store import mq_prob_pkg::*; #(
  parameter int NCTX = 19,
  parameter int CXW  = 5,
  parameter logic [NCTX*IW-1:0] INIT_IDX = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CXW-1:0]  rd_cx,
  input  logic            wr_en,
  input  logic [CXW-1:0]  wr_cx,
  input  ctx_word_t       wr_data,
  output ctx_word_t       rd_data
);
  ctx_word_t ent [NCTX];
  ctx_word_t rd_d;

  for (genvar k = 0; k < NCTX; k++) begin : g_ent
    ctx_word_t q;
    logic      we;
    always_comb we = wr_en && (wr_cx == CXW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= {1'b0, row_of(INIT_IDX[k*IW +: IW])};
      else if (we)  q <= wr_data;
    end
    assign ent[k] = q;
  end

  // distance-two forward: the pending write has not landed yet
  always_comb begin
    if (wr_en && (wr_cx == rd_cx)) rd_d = wr_data;
    else                           rd_d = ent[rd_cx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_data <= '0;
    else if (en) rd_data <= rd_d;
  end

  a_r6_row_live: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data.row.qe != '0) && (wr_data.row.qsh != '0));
endmodule

// File: rtl/mq_interval.sv
module mq_interval import mq_prob_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           vld,
  input  logic           sym,
  input  logic           mps,
  input  logic [PW-1:0]  qe,
  input  logic [SHW-1:0] qsh,
  output logic           hit,
  output logic [PW-1:0]  prob,
  output logic [SHW-1:0] shift
);
  logic [PW-1:0]  a_q, a_d, am;
  logic [SHW-1:0] sub_sh;

  always_comb begin
    am     = a_q - qe;
    sub_sh = am[PW-2] ? SHW'(1) : SHW'(2);
    hit    = 1'b1;
    prob   = qe;
    shift  = '0;
    a_d    = a_q;
    if (sym == mps) begin
      if (am[PW-1]) begin
        a_d = am;
      end else if (am < qe) begin
        a_d = qe << qsh; hit = 1'b0; prob = '0; shift = qsh;
      end else begin
        a_d = am << sub_sh; shift = sub_sh;
      end
    end else begin
      if (am < qe) begin
        a_d = am << sub_sh; shift = sub_sh;
      end else begin
        a_d = qe << qsh; hit = 1'b0; prob = '0; shift = qsh;
      end
    end
    if (!vld) a_d = a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  a_q <= 16'h8000;
    else if (en) a_q <= a_d;
  end

  a_r5_a_norm: assert property (@(posedge clk) disable iff (!rst_n) a_q[PW-1]);
  a_r5_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && am < 16'h8000 && ((sym != mps) ? (am < qe) : (am >= qe))) |-> (am[PW-2] || am[PW-3]));
endmodule

// File: rtl/mq_prob_stage.sv
module mq_prob_stage import mq_prob_pkg::*; #(
  parameter int NCTX = 19,
  parameter int CXW  = (NCTX > 1) ? $clog2(NCTX) : 1,
  parameter logic [NCTX*IW-1:0] INIT_IDX = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CXW-1:0] in_cx,
  input  logic           in_bit,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [3:0]     out_shift,
  output logic [15:0]    out_prob,
  output logic           out_hit
);
  logic [1:0]     rs_q;
  logic           rst_i;
  logic           en;
  logic           r1_v_q, r1_bit_q, r1_byp_q;
  logic [CXW-1:0] r1_cx_q;
  logic           wb_v_q;
  logic [CXW-1:0] wb_cx_q;
  ctx_word_t      wb_word_q, rd_word, cur, nxt_word;
  logic           lps;
  logic [IW-1:0]  nidx;
  st_row_t        rom_row;
  logic           hit;
  logic [PW-1:0]  prob;
  logic [SHW-1:0] sh;
  logic           o_v_q, o_hit_q;
  logic [PW-1:0]  o_prob_q;
  logic [SHW-1:0] o_sh_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign en       = !o_v_q || out_ready;
  assign in_ready = en;

  // stage 1: capture pair, note a back-to-back repeat
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      r1_v_q <= 1'b0; r1_bit_q <= 1'b0; r1_byp_q <= 1'b0; r1_cx_q <= '0;
    end else if (en) begin
      r1_v_q   <= in_valid;
      r1_bit_q <= in_bit;
      r1_cx_q  <= in_cx;
      r1_byp_q <= in_valid && r1_v_q && (r1_cx_q == in_cx);
    end
  end

  mq_ctx_store #(.NCTX(NCTX), .CXW(CXW), .INIT_IDX(INIT_IDX)) u_store (
    .clk(clk), .rst_n(rst_i), .en(en), .rd_cx(in_cx),
    .wr_en(en && wb_v_q), .wr_cx(wb_cx_q), .wr_data(wb_word_q),
    .rd_data(rd_word)
  );

  // stage 2: select context info, adapt state
  always_comb begin
    cur      = r1_byp_q ? wb_word_q : rd_word;
    lps      = (r1_bit_q != cur.mps);
    nidx     = lps ? cur.row.nl : cur.row.nm;
    nxt_word = cur;
    if (lps) begin
      nxt_word.row = rom_row;
      nxt_word.mps = cur.mps ^ cur.row.sw;
    end else if (sh != '0) begin
      nxt_word.row = rom_row;
    end
  end

  mq_state_rom u_rom (.idx(nidx), .row(rom_row));

  mq_interval u_int (
    .clk(clk), .rst_n(rst_i), .en(en), .vld(r1_v_q), .sym(r1_bit_q),
    .mps(cur.mps), .qe(cur.row.qe), .qsh(cur.row.qsh),
    .hit(hit), .prob(prob), .shift(sh)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wb_v_q <= 1'b0; wb_cx_q <= '0; wb_word_q <= '0;
      o_v_q <= 1'b0; o_hit_q <= 1'b0; o_prob_q <= '0; o_sh_q <= '0;
    end else if (en) begin
      wb_v_q    <= r1_v_q;
      wb_cx_q   <= r1_cx_q;
      wb_word_q <= nxt_word;
      o_v_q     <= r1_v_q;
      o_hit_q   <= hit;
      o_prob_q  <= prob;
      o_sh_q    <= sh;
    end
  end

  assign out_valid = o_v_q;
  assign out_hit   = o_hit_q;
  assign out_prob  = o_prob_q;
  assign out_shift = o_sh_q;

  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_i)
    !out_valid |-> in_ready);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |=> out_valid && $stable(out_shift) && $stable(out_prob) && $stable(out_hit));
  a_r3_noshift_hits: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && out_shift == '0) |-> out_hit);
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_hit) |-> (out_prob == '0) && (out_shift != '0));
  a_r5_hit_shift: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && out_hit) |-> (out_shift <= 4'd2) && (out_prob != '0));
  a_r11_cx_range: assert property (@(posedge clk) disable iff (!rst_i)
    in_valid |-> (in_cx < CXW'(NCTX)));
endmodule

// File: tb/tb_mq_prob_stage.sv
`timescale 1ns/1ps
module tb_mq_prob_stage;
  localparam int NC = 6;
  localparam int CW = 3;
  localparam logic [NC*6-1:0] INIT = (36'd5 << 18) | (36'd3 << 24);

  localparam int QE_T [47] = '{'h5601,'h3401,'h1801,'h0AC1,'h0521,'h0221,'h5601,'h5401,
    'h4801,'h3801,'h3001,'h2401,'h1C01,'h1601,'h5601,'h5401,'h5101,'h4801,'h3801,'h3401,
    'h3001,'h2801,'h2401,'h2201,'h1C01,'h1801,'h1601,'h1401,'h1201,'h1101,'h0AC1,'h09C1,
    'h08A1,'h0521,'h0441,'h02A1,'h0221,'h0141,'h0111,'h0085,'h0049,'h0025,'h0015,'h0009,
    'h0005,'h0001,'h5601};
  localparam int NM_T [47] = '{1,2,3,4,5,38,7,8,9,10,11,12,13,29,15,16,17,18,19,20,21,22,
    23,24,25,26,27,28,29,30,31,32,33,34,35,36,37,38,39,40,41,42,43,44,45,45,46};
  localparam int NL_T [47] = '{1,6,9,12,29,33,6,14,14,14,17,18,20,21,14,14,15,16,17,18,19,
    19,20,21,22,23,24,25,26,27,28,29,30,31,32,33,34,35,36,37,38,39,40,41,42,43,46};

  logic clk = 1'b0;
  logic rst_n, in_valid, in_bit, out_ready, out_valid, out_hit, in_ready;
  logic [CW-1:0] in_cx;
  logic [3:0] out_shift;
  logic [15:0] out_prob;

  always #2.5 clk = ~clk;

  mq_prob_stage #(.NCTX(NC), .CXW(CW), .INIT_IDX(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_cx(in_cx),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready), .out_shift(out_shift),
    .out_prob(out_prob), .out_hit(out_hit)
  );

  int nchk = 0, nbad = 0, cyc = 0;
  int m_idx [NC];
  bit m_mps [NC];
  int m_a;
  int e_rec [1024];
  int e_stamp [1024];
  string e_tag [1024];
  int wp = 0, rp = 0;
  bit stall_mode = 0, lat_mode = 0, live = 0, held = 0, finished = 0;
  int held_rec;
  string phase = "";

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input int cx, input bit b, output int rec, output string tg);
    int qe, am, hit, p, s;
    qe = QE_T[m_idx[cx]]; am = m_a - qe; hit = 1; p = qe;
    if (b == m_mps[cx]) begin
      if (am >= 32768) begin m_a = am; tg = "R3"; end
      else begin
        if (am < qe) begin m_a = qe; hit = 0; p = 0; end else m_a = am;
        m_idx[cx] = NM_T[m_idx[cx]]; tg = "R4 R5 R6";
      end
    end else begin
      if (am < qe) m_a = am; else begin m_a = qe; hit = 0; p = 0; end
      if (m_idx[cx] == 0 || m_idx[cx] == 6 || m_idx[cx] == 14) m_mps[cx] = ~m_mps[cx];
      m_idx[cx] = NL_T[m_idx[cx]]; tg = "R4 R5 R6";
    end
    s = 0;
    while (m_a < 32768) begin m_a = m_a * 2; s++; end
    rec = (hit << 20) | (p << 4) | s;
  endtask

  // output monitor, acts half a cycle away from the active edge
  always begin
    @(negedge clk);
    cyc++;
    out_ready = stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
    #1;
    if (live) begin
      int act;
      act = (int'(out_hit) << 20) | (int'(out_prob) << 4) | int'(out_shift);
      if (held) chk("R9 record held", out_valid && act == held_rec, act, held_rec);
      held = 0;
      if (out_valid && !out_ready) begin
        held = 1; held_rec = act;
        chk("R9 in_ready low under back-pressure", !in_ready, in_ready, 0);
      end
      if (out_valid && out_ready) begin
        if (rp == wp) chk("R2 unexpected record", 0, act, 0);
        else begin
          chk({phase, " ", e_tag[rp % 1024]}, act == e_rec[rp % 1024], act, e_rec[rp % 1024]);
          if (lat_mode) chk("R2 latency", cyc == e_stamp[rp % 1024] + 2, cyc, e_stamp[rp % 1024] + 2);
          rp++;
        end
      end
    end
  end

  task automatic put(input int cx, input bit b);
    int rec; string tg;
    in_cx = CW'(cx); in_bit = b; in_valid = 1'b1;
    while (1) begin
      if (in_ready) begin
        model(cx, b, rec, tg);
        e_rec[wp % 1024] = rec; e_tag[wp % 1024] = tg; e_stamp[wp % 1024] = cyc;
        wp++;
        @(negedge clk); #2;
        break;
      end
      @(negedge clk); #2;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && rp != wp; i++) begin @(negedge clk); #2; end
    chk("R2 all records delivered", rp == wp, rp, wp);
  endtask

  function automatic bit pick(input int cx, input int lps_odds);
    return m_mps[cx] ^ ($urandom_range(0, lps_odds - 1) == 0);
  endfunction

  initial begin
    #750000;
    if (!finished) begin
      finished = 1; nbad++; nchk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) begin m_idx[k] = int'(INIT[k*6 +: 6]); m_mps[k] = 0; end
    m_a = 'h8000;
    in_valid = 1'b0; in_cx = '0; in_bit = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R1 out_valid low", out_valid == 1'b0, out_valid, 0);
    chk("R1 in_ready high", in_ready == 1'b1, in_ready, 1);
    live = 1; lat_mode = 1;

    // R10: configured and default starting states (first qe 0x0221, 0x0AC1, 0x5601)
    phase = "R10 R1";
    put(3, 0); put(4, 0); put(5, 0);
    // R3: long run of correct predictions on one context
    phase = "R3";
    for (int i = 0; i < 60; i++) put(0, 0);
    // R6: wrong prediction at a switching state, then the inverted prediction
    phase = "R6";
    put(1, 1); put(1, 1); put(1, 0); put(1, 1);
    // R7: back-to-back repeats on one context
    phase = "R7";
    for (int i = 0; i < 400; i++) put(2, pick(2, 3));
    // R8: alternate two contexts (distance-two repeats)
    phase = "R8";
    for (int i = 0; i < 400; i++) put(i % 2, pick(i % 2, 3));
    for (int i = 0; i < 300; i++) put((i % 3 == 1) ? 5 : 4, pick((i % 3 == 1) ? 5 : 4, 2));
    drain();
    // R11: all contexts interleaved, random decisions and gaps
    phase = "R11";
    for (int i = 0; i < 6000; i++) begin
      int c;
      c = $urandom_range(0, NC - 1);
      put(c, ($urandom_range(0, 3) == 0) ? 1'($urandom_range(0, 1)) : pick(c, 6));
      if ($urandom_range(0, 9) == 0) begin in_valid = 1'b0; @(negedge clk); #2; end
    end
    drain();
    // R9: random back-pressure with dense repeats
    phase = "R9";
    lat_mode = 0; stall_mode = 1;
    for (int i = 0; i < 6000; i++) begin
      int c;
      c = ($urandom_range(0, 1) == 0) ? (i % 2) : $urandom_range(0, NC - 1);
      put(c, pick(c, 4));
    end
    stall_mode = 0;
    drain();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule